// File: doc/BRIEF.md
# Nine-Bit Serial Port with Address Filtering

This block is an asynchronous serial transmitter and receiver whose character can carry seven, eight or nine data bits. The ninth bit serves as a marker in a multi-drop network. When a node sets its attention bit, the receiver throws away every data character, meaning every character whose ninth bit is 0. It accepts the first character whose ninth bit is 1, treats that character as an address, and clears the attention bit by itself. Software then inspects the address. If the address is its own, software leaves attention off and takes the data that follows. If not, it sets attention again.

A length code of 3 selects a diagnostic loopback. In this mode the transmit shifter drives the receive shifter internally, and the frames are nine bits long. A one-cycle reinitialize pulse puts the transmitter at rest and clears the read-only flags. It leaves the control bits, the transmit holding buffer and the received character as they were.

The baud rate is set outside the block through `tick16`, an enable that is high once per 1/16 of a bit. Software reaches the block over a small register bus with four addresses:
- Address 0: write to load a transmit character, read to take the received character.
- Address 1: control register.
- Address 2: status register.
- Address 3: reads back the transmit holding buffer.

Top module: `nine_bit_uart`

## Requirements
- R1: After reset, `tx_pin` is 1, `irq` is 0, the status register (address 2) reads 0x10 and the control register (address 1) reads 0x00. Status bits: bit0 received ninth bit, bit1 framing error, bit2 overrun, bit3 receive full, bit4 transmit holding buffer empty.
- R2: A write to address 0 sends one frame on `tx_pin`, least significant bit first: a 0 start bit, the data bits, then a 1 stop bit. Each bit lasts 16 `tick16` pulses. Control bits 4:3 are the length code: 0 gives 8 bits, 1 gives 7 bits, 2 and 3 give 9 bits.
- R3: In 9-bit frames the transmitted ninth bit equals control bit0.
- R4: A low level on the receive line that is gone by the 8th tick is not a start bit and produces no character.
- R5: A received character goes to address 0 and sets receive full. `irq` is high while receive full is set and control bit2 is 1. Reading address 0 clears receive full.
- R6: The received ninth bit is reported in status bit0. In 7-bit frames the character is right-justified with bit7 equal to 0.
- R7: A stop bit sampled low sets the framing error flag. A read of address 2 clears both the framing error and overrun flags.
- R8: A character that completes while receive full is set sets the overrun flag and leaves the held character unchanged.
- R9: While control bit1 (attention) is 1, a character whose ninth bit is 0 is discarded: receive full, the held character and attention are all unchanged.
- R10: In attention mode, a character whose ninth bit is 1 is accepted and clears attention. After that, characters with either ninth-bit value are accepted.
- R11: Attention mode does not change the transmitter, and transmitting does not clear attention.
- R12: With length code 3, transmitted frames are received internally as 9-bit characters. `tx_pin` stays 1 and `rx_pin` is ignored.
- R13: A reinitialize pulse forces `tx_pin` to 1 and abandons any frame in progress. It sets status to 0x10 and keeps the control register, the received character and the transmit holding buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable, 16 per bit time |
| reinit | input | 1 | One-cycle low-power reinitialize pulse |
| rx_pin | input | 1 | Serial receive line |
| tx_pin | output | 1 | Serial transmit line |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (has side effects) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from address |
| irq | output | 1 | Receive-full interrupt |

## Verification
The hardest state to reach is the reinitialize pulse arriving while the transmitter is in mid-frame, with a second character waiting in the holding buffer and an unread character in the receiver. The stimulus reaches it in three steps. It first receives a character and leaves it unread. It then starts a transmit frame and, a few bit times in, writes a second character so that the holding buffer is full. Only then does it fire the pulse. After the pulse it checks four things: the line stays high for a whole frame time, the status register reads 0x10, and both buffers read back their old contents. The attention tests mix discarded data characters, an accepted address character and a following data character. This shows the attention bit clearing itself at the right character.

// File: rtl/nine_bit_uart_pkg.sv
package nine_bit_uart_pkg;
    localparam int MAXB = 9;
    localparam int FW   = MAXB + 2;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_st_t;

    typedef enum logic [1:0] {
        LEN_8    = 2'd0,
        LEN_7    = 2'd1,
        LEN_9    = 2'd2,
        LEN_LOOP = 2'd3
    } len_t;

    function automatic logic [3:0] len_bits(input logic [1:0] code);
        case (code)
            LEN_8:   len_bits = 4'd8;
            LEN_7:   len_bits = 4'd7;
            default: len_bits = 4'd9;
        endcase
    endfunction
endpackage

// File: rtl/nine_bit_uart_tx.sv
module nine_bit_uart_tx
    import nine_bit_uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            reinit,
    input  logic            load,
    input  logic [MAXB-1:0] data,
    input  logic [3:0]      nbits,
    output logic            txd,
    output logic            busy
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    typedef struct packed {
        logic [FW-1:0] sh;
        logic [CW-1:0] sub;
        logic [3:0]    bitn;
        logic          busy;
    } tx_s_t;

    tx_s_t q, d;

    always_comb begin
        d = q;
        if (!q.busy && load) begin
            d.sh = '1;
            d.sh[0] = 1'b0;
            for (int i = 0; i < MAXB; i++) begin
                if (4'(i) < nbits) d.sh[i+1] = data[i];
            end
            d.sub  = '0;
            d.bitn = '0;
            d.busy = 1'b1;
        end else if (q.busy && tick) begin
            if (q.sub == LAST) begin
                d.sub = '0;
                d.sh  = {1'b1, q.sh[FW-1:1]};
                if (q.bitn == nbits + 4'd1) d.busy = 1'b0;
                else                        d.bitn = q.bitn + 4'd1;
            end else begin
                d.sub = q.sub + 1'b1;
            end
        end
        if (reinit) begin
            d.sh   = '1;
            d.sub  = '0;
            d.bitn = '0;
            d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sh: '1, sub: '0, bitn: '0, busy: 1'b0};
        else        q <= d;
    end

    assign txd  = q.sh[0];
    assign busy = q.busy;

    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
    a_r13_reinit_idle: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (txd && !busy));
endmodule

// File: rtl/nine_bit_uart_rx.sv
module nine_bit_uart_rx
    import nine_bit_uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            rxd,
    input  logic [3:0]      nbits,
    output logic            done,
    output logic [MAXB-1:0] data,
    output logic            stop_ok
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);

    typedef struct packed {
        rx_st_t          st;
        logic [CW-1:0]   sub;
        logic [3:0]      bitn;
        logic [MAXB-1:0] sh;
        logic            done;
        logic [MAXB-1:0] data;
        logic            stop_ok;
    } rx_s_t;

    rx_s_t q, d;
    logic [3:0] shamt;

    assign shamt = 4'(MAXB) - nbits;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (tick) begin
            case (q.st)
                RX_IDLE: begin
                    if (!rxd) begin
                        d.st  = RX_START;
                        d.sub = '0;
                    end
                end
                RX_START: begin
                    if (q.sub == MID) begin
                        d.sub  = '0;
                        d.bitn = '0;
                        d.st   = rxd ? RX_IDLE : RX_DATA;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (q.sub == LAST) begin
                        d.sub = '0;
                        d.sh  = {rxd, q.sh[MAXB-1:1]};
                        if (q.bitn == nbits - 4'd1) d.st = RX_STOP;
                        else                        d.bitn = q.bitn + 4'd1;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
                default: begin
                    if (q.sub == LAST) begin
                        d.done    = 1'b1;
                        d.stop_ok = rxd;
                        d.data    = q.sh >> shamt;
                        d.st      = RX_IDLE;
                        d.sub     = '0;
                    end else begin
                        d.sub = q.sub + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RX_IDLE, sub: '0, bitn: '0, sh: '0,
                           done: 1'b0, data: '0, stop_ok: 1'b1};
        else        q <= d;
    end

    assign done    = q.done;
    assign data    = q.data;
    assign stop_ok = q.stop_ok;

    a_r4_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_START && tick && q.sub == MID && rxd) |=> q.st == RX_IDLE);
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/nine_bit_uart.sv
module nine_bit_uart
    import nine_bit_uart_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       reinit,
    input  logic       rx_pin,
    output logic       tx_pin,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_TBUF = 2'd3;

    typedef struct packed {
        logic [7:0] tbuf;
        logic       tbmt;
        logic       tx9;
        logic       attn;
        logic       irq_en;
        logic [1:0] len;
        logic [7:0] rbuf;
        logic       rx9;
        logic       rx_full;
        logic       fe;
        logic       oe;
        logic [1:0] sync;
    } top_s_t;

    top_s_t q, d;

    logic            tx_line, tx_busy, tx_load;
    logic            rx_done, rx_stop_ok, rx_in, rx_bit9, rx_keep;
    logic [MAXB-1:0] rx_data;
    logic [3:0]      nbits;
    logic            loop_mode, wr_ctrl;

    assign nbits     = len_bits(q.len);
    assign loop_mode = (q.len == LEN_LOOP);
    assign tx_load   = !tx_busy && !q.tbmt;
    assign rx_in     = loop_mode ? tx_line : q.sync[1];
    assign rx_bit9   = q.len[1] & rx_data[MAXB-1];
    assign rx_keep   = !(q.attn && !rx_bit9);
    assign wr_ctrl   = wr_en && addr == A_CTRL;

    nine_bit_uart_tx #(.OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .reinit(reinit),
        .load(tx_load), .data({q.tx9, q.tbuf}), .nbits(nbits),
        .txd(tx_line), .busy(tx_busy)
    );

    nine_bit_uart_rx #(.OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rx_in), .nbits(nbits),
        .done(rx_done), .data(rx_data), .stop_ok(rx_stop_ok)
    );

    always_comb begin
        d = q;
        d.sync = {q.sync[0], rx_pin};
        if (tx_load) d.tbmt = 1'b1;
        if (wr_en && addr == A_DATA) begin
            d.tbuf = wdata;
            d.tbmt = 1'b0;
        end
        if (rd_en && addr == A_DATA) d.rx_full = 1'b0;
        if (rd_en && addr == A_STAT) begin
            d.fe = 1'b0;
            d.oe = 1'b0;
        end
        if (rx_done && rx_keep) begin
            if (q.rx_full) begin
                d.oe = 1'b1;
            end else begin
                d.rbuf    = rx_data[7:0];
                d.rx9     = rx_bit9;
                d.rx_full = 1'b1;
                d.fe      = !rx_stop_ok;
            end
            if (q.attn) d.attn = 1'b0;
        end
        if (wr_ctrl) begin
            d.tx9    = wdata[0];
            d.attn   = wdata[1];
            d.irq_en = wdata[2];
            d.len    = wdata[4:3];
        end
        if (reinit) begin
            d.tbmt    = 1'b1;
            d.rx9     = 1'b0;
            d.rx_full = 1'b0;
            d.fe      = 1'b0;
            d.oe      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{tbuf: '0, tbmt: 1'b1, tx9: 1'b0, attn: 1'b0,
                           irq_en: 1'b0, len: 2'd0, rbuf: '0, rx9: 1'b0,
                           rx_full: 1'b0, fe: 1'b0, oe: 1'b0, sync: 2'b11};
        else        q <= d;
    end

    always_comb begin
        case (addr)
            A_DATA:  rdata = q.rbuf;
            A_CTRL:  rdata = {3'b000, q.len, q.irq_en, q.attn, q.tx9};
            A_STAT:  rdata = {3'b000, q.tbmt, q.rx_full, q.oe, q.fe, q.rx9};
            default: rdata = q.tbuf;
        endcase
    end

    assign tx_pin = loop_mode ? 1'b1 : tx_line;
    assign irq    = q.irq_en & q.rx_full;

    a_r9_attn_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && q.attn && !rx_bit9 && !rd_en && !reinit)
            |=> ($stable(q.rx_full) && $stable(q.rbuf)));
    a_r10_attn_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && q.attn && rx_bit9 && !wr_ctrl) |=> !q.attn);
    a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !q.attn && q.rx_full && !rd_en && !reinit)
            |=> (q.oe && $stable(q.rbuf)));
    a_r13_flags: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (q.tbmt && !q.rx_full && !q.fe && !q.oe && !q.rx9));
    a_r12_loop_pin: assert property (@(posedge clk) disable iff (!rst_n)
        loop_mode |-> tx_pin);
endmodule

// File: tb/nine_bit_uart_bench.sv
`timescale 1ns/1ps
module nine_bit_uart_bench;
    localparam int BT = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       reinit = 1'b0;
    logic       rx_pin = 1'b1;
    logic       tx_pin;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    logic       done_flag = 1'b0;
    logic [1:0] tdiv = 2'd0;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= tdiv[0];
    end

    nine_bit_uart u_nine_bit_uart (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .reinit(reinit),
        .rx_pin(rx_pin), .tx_pin(tx_pin), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send_rx(input logic [8:0] v, input int nb, input logic stopv);
        @(negedge clk);
        rx_pin = 1'b0;
        repeat (BT) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rx_pin = v[i];
            repeat (BT) @(negedge clk);
        end
        rx_pin = stopv;
        repeat (BT) @(negedge clk);
        rx_pin = 1'b1;
        repeat (BT) @(negedge clk);
    endtask

    task automatic cap_tx(input int nb, output logic [8:0] v, output logic stopv);
        int guard = 0;
        v = '0;
        stopv = 1'b0;
        while (tx_pin !== 1'b0 && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        repeat (BT / 2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            repeat (BT) @(negedge clk);
            v[i] = tx_pin;
        end
        repeat (BT) @(negedge clk);
        stopv = tx_pin;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 tx_pin", int'(tx_pin), 1);
        chk("R1 irq", int'(irq), 0);
        bus_rd(2'd2, v); chk("R1 status", int'(v), 'h10);
        bus_rd(2'd1, v); chk("R1 control", int'(v), 'h00);
    endtask

    task automatic t_tx8;
        logic [8:0] c; logic s;
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd0, 8'hA5);
        cap_tx(8, c, s);
        chk("R2 8-bit data", int'(c), 'hA5);
        chk("R2 stop bit", int'(s), 1);
        bus_wr(2'd1, 8'h08);
        bus_wr(2'd0, 8'h35);
        cap_tx(8, c, s);
        chk("R2 7-bit frame", int'(c), 'hB5);
    endtask

    task automatic t_tx9;
        logic [8:0] c; logic s;
        bus_wr(2'd1, 8'h11);
        bus_wr(2'd0, 8'h3C);
        cap_tx(9, c, s);
        chk("R3 ninth bit one", int'(c), 'h13C);
        chk("R3 stop", int'(s), 1);
        bus_wr(2'd1, 8'h10);
        bus_wr(2'd0, 8'hC3);
        cap_tx(9, c, s);
        chk("R3 ninth bit zero", int'(c), 'h0C3);
        repeat (2 * BT) @(negedge clk);
    endtask

    task automatic t_glitch;
        logic [7:0] v;
        bus_wr(2'd1, 8'h00);
        @(negedge clk);
        rx_pin = 1'b0;
        repeat (6) @(negedge clk);
        rx_pin = 1'b1;
        repeat (12 * BT) @(negedge clk);
        bus_rd(2'd2, v); chk("R4 no character from glitch", int'(v & 8'h08), 0);
    endtask

    task automatic t_rx8;
        logic [7:0] v;
        bus_wr(2'd1, 8'h04);
        send_rx(9'h05A, 8, 1'b1);
        chk("R5 irq raised", int'(irq), 1);
        bus_rd(2'd2, v); chk("R5 status full", int'(v), 'h18);
        bus_rd(2'd0, v); chk("R5 data", int'(v), 'h5A);
        chk("R5 irq cleared", int'(irq), 0);
        bus_rd(2'd2, v); chk("R5 full cleared", int'(v & 8'h08), 0);
    endtask

    task automatic t_rx7_9;
        logic [7:0] v;
        bus_wr(2'd1, 8'h08);
        send_rx(9'h1FF, 7, 1'b1);
        bus_rd(2'd0, v); chk("R6 7-bit justify", int'(v), 'h7F);
        bus_wr(2'd1, 8'h10);
        send_rx(9'h1A6, 9, 1'b1);
        bus_rd(2'd2, v); chk("R6 rx9 flag", int'(v & 8'h01), 1);
        bus_rd(2'd0, v); chk("R6 9-bit data", int'(v), 'hA6);
    endtask

    task automatic t_frame_err;
        logic [7:0] v;
        bus_wr(2'd1, 8'h00);
        send_rx(9'h033, 8, 1'b0);
        bus_rd(2'd2, v); chk("R7 framing set", int'(v & 8'h02), 2);
        bus_rd(2'd2, v); chk("R7 framing cleared", int'(v & 8'h02), 0);
        bus_rd(2'd0, v);
    endtask

    task automatic t_overrun;
        logic [7:0] v;
        send_rx(9'h011, 8, 1'b1);
        send_rx(9'h022, 8, 1'b1);
        bus_rd(2'd2, v); chk("R8 overrun set", int'(v & 8'h04), 4);
        bus_rd(2'd0, v); chk("R8 first kept", int'(v), 'h11);
        bus_rd(2'd2, v); chk("R8 overrun cleared", int'(v & 8'h04), 0);
    endtask

    task automatic t_attn;
        logic [7:0] v;
        bus_wr(2'd1, 8'h12);
        send_rx(9'h012, 9, 1'b1);
        bus_rd(2'd2, v); chk("R9 data dropped", int'(v & 8'h08), 0);
        bus_rd(2'd1, v); chk("R9 attn kept", int'(v), 'h12);
        send_rx(9'h1A7, 9, 1'b1);
        bus_rd(2'd1, v); chk("R10 attn self-clear", int'(v), 'h10);
        bus_rd(2'd2, v); chk("R10 address status", int'(v), 'h19);
        bus_rd(2'd0, v); chk("R10 address data", int'(v), 'hA7);
        send_rx(9'h033, 9, 1'b1);
        bus_rd(2'd0, v); chk("R10 data after clear", int'(v), 'h33);
    endtask

    task automatic t_attn_tx;
        logic [8:0] c; logic s; logic [7:0] v;
        bus_wr(2'd1, 8'h13);
        bus_wr(2'd0, 8'h5E);
        cap_tx(9, c, s);
        chk("R11 tx in attention", int'(c), 'h15E);
        repeat (2 * BT) @(negedge clk);
        bus_rd(2'd1, v); chk("R11 attn untouched", int'(v), 'h13);
    endtask

    task automatic t_loop;
        logic [7:0] v;
        int hi = 1;
        bus_wr(2'd1, 8'h19);
        rx_pin = 1'b0;
        bus_wr(2'd0, 8'hC3);
        for (int i = 0; i < 13 * BT; i++) begin
            @(negedge clk);
            if (tx_pin !== 1'b1) hi = 0;
        end
        rx_pin = 1'b1;
        chk("R12 pin idle", hi, 1);
        bus_rd(2'd2, v); chk("R12 status", int'(v), 'h19);
        bus_rd(2'd0, v); chk("R12 looped data", int'(v), 'hC3);
    endtask

    task automatic t_reinit;
        logic [7:0] v;
        int hi = 1;
        bus_wr(2'd1, 8'h04);
        send_rx(9'h06B, 8, 1'b1);
        bus_wr(2'd0, 8'h11);
        repeat (3 * BT) @(negedge clk);
        bus_wr(2'd0, 8'h22);
        @(negedge clk);
        reinit = 1'b1;
        @(negedge clk);
        reinit = 1'b0;
        for (int i = 0; i < 12 * BT; i++) begin
            if (tx_pin !== 1'b1) hi = 0;
            @(negedge clk);
        end
        chk("R13 line idle", hi, 1);
        chk("R13 irq low", int'(irq), 0);
        bus_rd(2'd2, v); chk("R13 status", int'(v), 'h10);
        bus_rd(2'd1, v); chk("R13 control kept", int'(v), 'h04);
        bus_rd(2'd0, v); chk("R13 rx buffer kept", int'(v), 'h6B);
        bus_rd(2'd3, v); chk("R13 tx buffer kept", int'(v), 'h22);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset;
        t_tx8;
        t_tx9;
        t_glitch;
        t_rx8;
        t_rx7_9;
        t_frame_err;
        t_overrun;
        t_attn;
        t_attn_tx;
        t_loop;
        t_reinit;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule